// File: doc/BRIEF.md
# Multi-lane SPI frame shifter

This block moves one serial frame of up to eight data bits between a transmit byte and a receive byte. The frame travels over one, two or four data lines. A clock sequencer outside the block decides when each bit group moves and signals it with a one-cycle `step` strobe. The block takes no part in clock generation or chip-select timing.

A frame begins when `start` is high while the block is idle. On that cycle the block latches the transmit byte and a 20-bit format word. The format word sets the lane mode, the bit order, a transmit-only flag and the frame length. The current bit group appears on `dq_out`, gated by `dq_oe`, and stays there until the next `step`. On each `step` the block samples the incoming group. After the last group it raises a one-cycle `done`. For a receive frame it raises `rx_valid` at the same time, with the collected byte right-aligned on `rx_data`.

Top module: `spi_lane_shifter`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `rx_valid` are low, `dq_oe` and `dq_out` are zero.
- R2: Format bits [1:0] select the lane count: 0 gives one lane, 1 gives two, 2 gives four, and 3 is treated as one lane. A frame of L effective bits over N lanes needs ceil(L/N) `step` strobes. `busy` rises the cycle after an accepted `start`. `done` pulses for one cycle, in the cycle after the last strobe, with `busy` low.
- R3: With format bit 2 clear, bits leave most-significant first. Bit L-1 goes out first, and within a group the earlier bit sits on the higher lane.
- R4: With format bit 2 set, bits leave least-significant first. Bit 0 goes out first, and within a group the earlier bit sits on lane 0.
- R5: In one-lane mode, lane 0 is the only driven output during a frame and lane 1 is the sampled input.
- R6: In two- or four-lane mode, `dq_oe` is zero for a receive frame and covers exactly the active lanes for a transmit-only frame. While idle, `dq_oe` is zero.
- R7: With format bit 3 set, the frame is transmit-only: no `rx_valid` pulse is produced.
- R8: The length field in format bits [19:16] is clamped to 8. A length of 0 pulses `done` the cycle after `start`, with no `busy` and no `rx_valid`.
- R9: A receive frame of L bits delivers the received bits in `rx_data[L-1:0]` in their original significance, with the upper bits zero.
- R10: A `start` while busy is ignored, and changes to the format word or transmit byte in mid-frame have no effect. Between strobes, `dq_out` and `dq_oe` stay constant.
- R11: A `step` while idle has no effect: it does not start a frame or produce `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_fmt | input | 20 | Format word: [1:0] lane mode, [2] LSB first, [3] transmit-only, [19:16] length |
| start | input | 1 | Request to begin a frame; accepted while idle |
| tx_byte | input | DATA_W | Byte to send, latched with start |
| step | input | 1 | Shift strobe from the clock sequencer |
| dq_in | input | LANES | Incoming lane levels |
| dq_out | output | LANES | Outgoing lane levels |
| dq_oe | output | LANES | Per-lane output enable |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at frame end |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a received byte |
| rx_data | output | DATA_W | Received byte, right-aligned |

## Verification
The assertions assume that `step` and `start` are single-cycle strobes. They also assume the sequencer never strobes faster than once per clock. They assume `dq_in` needs to be valid only in the cycle that `step` is high. The bench drives every input on the falling clock edge and raises `step` for one cycle per group, with an idle cycle between strobes. It changes `cfg_fmt` and `tx_byte` in mid-frame only in the test that checks they are ignored.

// File: rtl/spi_lane_pkg.sv
// Package for the lane shifter.
// Holds the format word layout, the decoded frame settings and the lane count for each mode.
// Assumes the 20-bit format word described in the brief.
package spi_lane_pkg;

    localparam int FMT_W      = 20;
    localparam int MODE_LSB   = 0;
    localparam int ORDER_BIT  = 2;
    localparam int TXONLY_BIT = 3;
    localparam int LEN_LSB    = 16;
    localparam int LEN_W      = 4;

    typedef enum logic [1:0] {
        LM_ONE  = 2'd0,
        LM_TWO  = 2'd1,
        LM_FOUR = 2'd2,
        LM_RSVD = 2'd3
    } lane_mode_e;

    typedef struct packed {
        lane_mode_e       mode;
        logic             lsb_first;
        logic             tx_only;
        logic [LEN_W-1:0] len;
    } frame_cfg_t;

    // Split a format word into its fields.
    function automatic frame_cfg_t unpack_fmt(input logic [FMT_W-1:0] w);
        frame_cfg_t c;
        c.mode      = lane_mode_e'(w[MODE_LSB +: 2]);
        c.lsb_first = w[ORDER_BIT];
        c.tx_only   = w[TXONLY_BIT];
        c.len       = w[LEN_LSB +: LEN_W];
        return c;
    endfunction

    // Number of active lanes for a mode; the reserved code behaves as one lane.
    function automatic logic [2:0] lane_count(input lane_mode_e m);
        case (m)
            LM_TWO:  return 3'd2;
            LM_FOUR: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/sls_lane_map.sv
// Lane map for the lane shifter.
// For the current group, gives each lane the bit position in the data byte that it carries.
// A lane is flagged as hit when it carries a real bit of the frame.
// Assumes lane_cnt is 1, 2 or 4 and len <= DATA_W.
module sls_lane_map #(
    parameter int DATA_W = 8,
    parameter int LANES  = 4,
    parameter int CW     = 4
) (
    input  logic [CW-1:0]                        grp,
    input  logic [2:0]                           lane_cnt,
    input  logic [CW-1:0]                        len,
    input  logic                                 lsb_first,
    output logic [LANES-1:0]                     hit,
    output logic [LANES-1:0][$clog2(DATA_W)-1:0] pos
);
    localparam int PW = $clog2(DATA_W);
    localparam int IW = 8;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [IW-1:0] order_idx;
        // Index of this lane's bit in transmission order.
        assign order_idx = IW'(grp) * IW'(lane_cnt)
                         + (lsb_first ? IW'(j) : (IW'(lane_cnt) - IW'(j) - IW'(1)));
        // The lane is active and its bit lies inside the frame.
        assign hit[j] = (IW'(j) < IW'(lane_cnt)) && (order_idx < IW'(len));
        // Map the transmission index to a significance in the byte.
        assign pos[j] = lsb_first ? PW'(order_idx) : PW'(IW'(len) - order_idx - IW'(1));
    end

endmodule

// File: rtl/sls_frame_ctrl.sv
// Frame sequencing for the lane shifter.
// Accepts a start while idle, counts step strobes up to the group count, and pulses done.
// A group count of zero completes on the start cycle without becoming busy.
// Assumes n_groups stays stable while busy.
module sls_frame_ctrl #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          step,
    input  logic [CW-1:0] n_groups,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] grp,
    output logic          last_step
);
    // Flag the final group of a running frame.
    assign last_step = busy && (grp == n_groups - CW'(1));

    // Busy flag, group counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            grp  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    if (n_groups == '0) begin
                        done <= 1'b1;
                    end else begin
                        busy <= 1'b1;
                        grp  <= '0;
                    end
                end
            end else if (step) begin
                if (last_step) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    grp <= grp + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/sls_rx_collect.sv
// Receive assembly for the lane shifter.
// Clears at frame start and stores each sampled lane bit at its mapped position.
// Bits that are never written stay zero, so the result is right-aligned.
// Assumes pos is only meaningful where hit is set.
module sls_rx_collect #(
    parameter int DATA_W = 8,
    parameter int LANES  = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clear,
    input  logic                                 capture,
    input  logic [LANES-1:0]                     hit,
    input  logic [LANES-1:0][$clog2(DATA_W)-1:0] pos,
    input  logic [LANES-1:0]                     in_bits,
    output logic [DATA_W-1:0]                    rx_q
);
    // Receive byte register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (clear) begin
            rx_q <= '0;
        end else if (capture) begin
            for (int j = 0; j < LANES; j++) begin
                if (hit[j]) rx_q[pos[j]] <= in_bits[j];
            end
        end
    end

endmodule

// File: rtl/spi_lane_shifter.sv
// Top of the multi-lane SPI frame shifter.
// Latches the format and transmit byte on start, presents one bit group per step interval,
// samples incoming groups on each step, and reports the received byte at frame end.
// Assumes LANES >= 4, DATA_W <= 8, and start/step are single-cycle strobes.
module spi_lane_shifter #(
    parameter int DATA_W = 8,
    parameter int LANES  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [spi_lane_pkg::FMT_W-1:0] cfg_fmt,
    input  logic                           start,
    input  logic [DATA_W-1:0]              tx_byte,
    input  logic                           step,
    input  logic [LANES-1:0]               dq_in,
    output logic [LANES-1:0]               dq_out,
    output logic [LANES-1:0]               dq_oe,
    output logic                           busy,
    output logic                           done,
    output logic                           rx_valid,
    output logic [DATA_W-1:0]              rx_data
);
    import spi_lane_pkg::*;

    localparam int CW = $clog2(DATA_W + 1);
    localparam int PW = $clog2(DATA_W);

    frame_cfg_t               cfg_live, cfg_q;
    logic [CW-1:0]            len_live, len_q, groups_live, groups_q, grp, n_groups;
    logic [2:0]               lanes_q;
    logic [DATA_W-1:0]        tx_q;
    logic                     accept, last_step, capture, single_q;
    logic [LANES-1:0]         hit, lane_mask, in_bits, out_bits;
    logic [LANES-1:0][PW-1:0] pos;

    assign cfg_live = unpack_fmt(cfg_fmt);
    assign accept   = start & ~busy;

    // Clamp the requested length to the byte width.
    always_comb begin
        if (int'(cfg_live.len) > DATA_W) len_live = CW'(DATA_W);
        else                             len_live = CW'(cfg_live.len);
    end

    // Group count: the length divided by the lane count, rounded up.
    always_comb begin
        case (cfg_live.mode)
            LM_TWO:  groups_live = (len_live + CW'(1)) >> 1;
            LM_FOUR: groups_live = (len_live + CW'(3)) >> 2;
            default: groups_live = len_live;
        endcase
    end

    assign n_groups = busy ? groups_q : groups_live;

    // Hold the frame settings and the transmit byte for the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            len_q    <= '0;
            groups_q <= '0;
            tx_q     <= '0;
        end else if (accept) begin
            cfg_q    <= cfg_live;
            len_q    <= len_live;
            groups_q <= groups_live;
            tx_q     <= tx_byte;
        end
    end

    assign lanes_q  = lane_count(cfg_q.mode);
    assign single_q = (lanes_q == 3'd1);

    for (genvar j = 0; j < LANES; j++) begin : g_mask
        assign lane_mask[j] = (j < int'(lanes_q));
        assign out_bits[j]  = hit[j] & tx_q[pos[j]];
    end

    sls_lane_map #(.DATA_W(DATA_W), .LANES(LANES), .CW(CW)) u_map (
        .grp       (grp),
        .lane_cnt  (lanes_q),
        .len       (len_q),
        .lsb_first (cfg_q.lsb_first),
        .hit       (hit),
        .pos       (pos)
    );

    sls_frame_ctrl #(.CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .step      (step),
        .n_groups  (n_groups),
        .busy      (busy),
        .done      (done),
        .grp       (grp),
        .last_step (last_step)
    );

    assign capture = step & busy & ~cfg_q.tx_only;
    assign in_bits = single_q ? LANES'(dq_in[1]) : dq_in;

    sls_rx_collect #(.DATA_W(DATA_W), .LANES(LANES)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (capture),
        .hit     (hit),
        .pos     (pos),
        .in_bits (in_bits),
        .rx_q    (rx_data)
    );

    // Output enables by lane mode and direction.
    always_comb begin
        if (!busy)                dq_oe = '0;
        else if (single_q)        dq_oe = LANES'(1);
        else if (cfg_q.tx_only)   dq_oe = lane_mask;
        else                      dq_oe = '0;
    end

    assign dq_out = out_bits & dq_oe;

    // Receive-ready pulse at the end of a receive frame.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_valid <= 1'b0;
        else        rx_valid <= step & last_step & ~cfg_q.tx_only;
    end

endmodule

// File: rtl/sls_checker.sv
// Assertion checker for the lane shifter, attached with bind.
// Assumes start and step are single-cycle strobes sampled on the rising edge.
module sls_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             step,
    input logic             busy,
    input logic             done,
    input logic             rx_valid,
    input logic [LANES-1:0] dq_out,
    input logic [LANES-1:0] dq_oe
);
    // R6: no lane is driven outside a frame.
    a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dq_oe == '0 && dq_out == '0));

    // R2: done comes from a strobe in a running frame or from a zero-length start.
    a_r2_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (($past(busy) && $past(step)) || $past(start)));

    // R2: done is reported with the frame already closed.
    a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: a received byte is only reported at frame end.
    a_r7_rx_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> done);

    // R11: a frame only begins from start.
    a_r11_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R10: lane levels hold between strobes.
    a_r10_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(step)) |-> ($stable(dq_out) && $stable(dq_oe)));

endmodule

bind spi_lane_shifter sls_checker #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .step     (step),
    .busy     (busy),
    .done     (done),
    .rx_valid (rx_valid),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
);

// File: tb/spi_lane_shifter_tb.sv
module spi_lane_shifter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;
    // {format[19:0], tx[7:0], peer[7:0], expected rx[7:0], groups[3:0]}
    localparam logic [47:0] VEC [NVEC] = '{
        {20'h80000, 8'hA5, 8'h3C, 8'h3C, 4'd8},
        {20'h80004, 8'h81, 8'hC3, 8'hC3, 4'd8},
        {20'h80001, 8'h96, 8'h5A, 8'h5A, 4'd4},
        {20'h50005, 8'h1F, 8'hF6, 8'h16, 4'd3},
        {20'h80002, 8'h7E, 8'hE1, 8'hE1, 4'd2},
        {20'h30006, 8'h05, 8'hFF, 8'h07, 4'd1},
        {20'hC0002, 8'hC9, 8'h9C, 8'h9C, 4'd2},
        {20'h40000, 8'h0B, 8'hAD, 8'h0D, 4'd4},
        {20'h80009, 8'h33, 8'h00, 8'h00, 4'd4},
        {20'h20003, 8'h02, 8'h01, 8'h01, 4'd2},
        {20'h6000E, 8'h2D, 8'h00, 8'h00, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] cfg_fmt = '0;
    logic        start = 1'b0;
    logic [7:0]  tx_byte = '0;
    logic        step = 1'b0;
    logic [3:0]  dq_in = '0;
    logic [3:0]  dq_out, dq_oe;
    logic        busy, done, rx_valid;
    logic [7:0]  rx_data;
    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_lane_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .start(start), .tx_byte(tx_byte),
        .step(step), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy),
        .done(done), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lanes_of(input logic [1:0] m);
        return (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
    endfunction

    // Bit of byte b carried on lane j in group g, per the ordering requirements.
    function automatic logic lane_bit(input logic [7:0] b, input int len, input bit lsb,
                                      input int g, input int j, input int nl);
        int k;
        if (j >= nl) return 1'b0;
        k = g * nl + (lsb ? j : nl - 1 - j);
        if (k >= len) return 1'b0;
        return lsb ? b[k] : b[len - 1 - k];
    endfunction

    // One frame: start, strobe each group, check lanes, then check the end of the frame.
    task automatic run_frame(input logic [19:0] fmt, input logic [7:0] tx, input logic [7:0] peer,
                             input logic [7:0] exp_rx, input int groups, input bit disturb);
        int nl, len;
        bit lsb, txo;
        logic [3:0] exp_oe, exp_out, drv;
        nl  = lanes_of(fmt[1:0]);
        lsb = fmt[2];
        txo = fmt[3];
        len = (fmt[19:16] > 4'd8) ? 8 : int'(fmt[19:16]);
        exp_oe = (nl == 1) ? 4'b0001 : (txo ? 4'((1 << nl) - 1) : 4'b0000);
        @(negedge clk);
        cfg_fmt = fmt; tx_byte = tx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R2 busy after start", busy, 1);
        for (int g = 0; g < groups; g++) begin
            if (disturb && g == 1) begin
                cfg_fmt = 20'h1000E; tx_byte = ~tx; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            exp_out = '0;
            drv = '0;
            for (int j = 0; j < 4; j++) exp_out[j] = lane_bit(tx, len, lsb, g, j, nl);
            exp_out = exp_out & exp_oe;
            if (nl == 1) drv[1] = lane_bit(peer, len, lsb, g, 0, 1);
            else for (int j = 0; j < 4; j++) drv[j] = lane_bit(peer, len, lsb, g, j, nl);
            chk(dq_oe === exp_oe, (nl == 1) ? "R5 lane enables" : "R6 lane enables", dq_oe, exp_oe);
            chk(dq_out === exp_out, disturb ? "R10 lanes after ignored start" :
                (lsb ? "R4 lane data" : "R3 lane data"), dq_out, exp_out);
            chk(done === 1'b0 && busy === 1'b1, "R2 frame still running", {busy, done}, 2'b10);
            dq_in = drv; step = 1'b1;
            @(negedge clk);
            step = 1'b0; dq_in = '0;
            if (g < groups - 1) @(negedge clk);
        end
        chk(done === 1'b1 && busy === 1'b0, "R2 done after last step", {busy, done}, 2'b01);
        chk(rx_valid === !txo, txo ? "R7 no rx on transmit-only" : "R9 rx_valid", rx_valid, !txo);
        if (!txo) chk(rx_data === exp_rx, (fmt[19:16] > 4'd8) ? "R8 clamped length" : "R9 rx data",
                      rx_data, exp_rx);
        @(negedge clk);
        chk(done === 1'b0 && rx_valid === 1'b0, "R2 done is one cycle", {done, rx_valid}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy === 0 && done === 0 && rx_valid === 0 && dq_oe === 0 && dq_out === 0,
            "R1 reset state", {busy, done, rx_valid, dq_oe, dq_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 0 && done === 0 && dq_oe === 0, "R1 idle after reset", {busy, done, dq_oe}, 0);

        for (int i = 0; i < NVEC; i++)
            run_frame(VEC[i][47:28], VEC[i][27:20], VEC[i][19:12], VEC[i][11:4], int'(VEC[i][3:0]), 1'b0);

        // R11: step while idle does nothing
        @(negedge clk);
        dq_in = 4'hF; step = 1'b1;
        @(negedge clk);
        step = 1'b0; dq_in = '0;
        chk(busy === 0 && done === 0 && dq_oe === 0, "R11 step while idle", {busy, done, dq_oe}, 0);
        @(negedge clk);
        chk(busy === 0 && done === 0 && rx_valid === 0, "R11 still idle", {busy, done, rx_valid}, 0);

        // R8: zero length completes at once
        @(negedge clk);
        cfg_fmt = 20'h00000; tx_byte = 8'hFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done === 1 && busy === 0 && rx_valid === 0, "R8 zero length", {done, busy, rx_valid}, 3'b100);
        @(negedge clk);
        chk(done === 0 && busy === 0, "R8 zero length one pulse", {done, busy}, 0);

        // R10: start and format changes in mid-frame are ignored
        run_frame(20'h80001, 8'hB4, 8'h6B, 8'h6B, 4, 1'b1);
        run_frame(20'h80000, 8'h5E, 8'h92, 8'h92, 8, 1'b1);

        // R1: reset in mid-frame returns to idle
        @(negedge clk);
        cfg_fmt = 20'h80000; start = 1'b1;
        @(negedge clk);
        start = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk(busy === 0 && dq_oe === 0 && done === 0, "R1 reset mid-frame", {busy, dq_oe, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule